// File: doc/BRIEF.md
# Timed Tag Insertion Delay Queue

The block sits between the demand-access path of a prefetch engine and the left bank of its recent-requests table. When delayed mode is active, every demand tag waits in a small FIFO before it is written into that bank. Each stored tag carries a release stamp. The oldest entry is written out once the free-running timestamp counter reaches that stamp. Because the table may be written only after the matching fill could have returned, a late write makes the table hold lines that have actually arrived.

When the queue already holds its full capacity, a new tag is dropped and the source never stalls. If `bypass_i` is high, a pushed tag skips the queue and is written into the bank on the next cycle. Entries already queued keep draining in that mode. Both paths share one write port, so a due release takes priority over a bypass tag that arrives in the same cycle.

Top module: `tag_delay_queue`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no push, `wr_valid_o` is 0.
- R2: A tag that is pushed with `bypass_i` low into a queue that is not full appears on `wr_tag_o` with `wr_valid_o` high in the cycle that follows the DELAY-th rising edge after the edge that sampled the push. No write happens in any cycle without a due entry or a bypass push.
- R3: A push with `bypass_i` low is discarded when the queue holds DEPTH entries before that edge. This holds even if an entry is released at the same edge. The discarded tag is never written.
- R4: Queued tags are written out in the order they were accepted, at most one per cycle.
- R5: With `bypass_i` high, a pushed tag appears on the write port one cycle after the edge that sampled it, unless a queued entry is due at that edge.
- R6: With `bypass_i` high, a push that arrives while a queued entry is due is discarded, and the queued entry is written.
- R7: The release timing stays correct after the internal timestamp counter wraps, including after idle gaps longer than the counter period.
- R8: A push and a release at the same edge leave the occupancy unchanged, and both tags are handled correctly.
- R9: A bypass push never enters the queue. Entries queued before bypass was raised still drain on their own schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bypass_i | input | 1 | 1: write pushed tags directly; 0: delay them through the queue |
| push_valid_i | input | 1 | Demand tag present this cycle |
| push_tag_i | input | TAG_W | Demand tag |
| wr_valid_o | output | 1 | Left-bank write strobe |
| wr_tag_o | output | TAG_W | Tag written into the left bank |

## Verification
On every cycle, the assertions check the write-port decision against the internal due flag:

- A due entry always produces a write.
- Nothing is written without a cause.
- A bypass tag appears one edge later.
- The occupancy never exceeds DEPTH, holds when a push and a release coincide, and never grows from a bypass push.

Only the bench's cycle-accurate reference can show that releases land exactly DELAY edges after acceptance, in FIFO order, across counter wraps. The same holds for showing which tags were dropped when the queue was full or when a bypass push collided with a release.

// File: rtl/tdq_pkg.sv
package tdq_pkg;
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_RELEASE = 2'd1,
    WR_BYPASS  = 2'd2
  } wr_src_e;

  function automatic int unsigned stamp_width(int unsigned delay, int unsigned depth);
    return $clog2(delay + depth + 1) + 1;
  endfunction
endpackage

// File: rtl/tdq_stamp_ctr.sv
module tdq_stamp_ctr #(
  parameter int unsigned TS_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] now_o
);
  logic [TS_W-1:0] now_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + 1'b1;
  end

  assign now_o = now_q;
endmodule

// File: rtl/tdq_ring.sv
module tdq_ring #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [W-1:0]               data_i,
  input  logic                       pop_i,
  output logic [W-1:0]               head_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/tag_delay_queue.sv
module tag_delay_queue
  import tdq_pkg::*;
#(
  parameter int unsigned TAG_W = 16,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DELAY = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bypass_i,
  input  logic             push_valid_i,
  input  logic [TAG_W-1:0] push_tag_i,
  output logic             wr_valid_o,
  output logic [TAG_W-1:0] wr_tag_o
);
  localparam int unsigned TS_W = stamp_width(DELAY, DEPTH);
  localparam int unsigned EW   = TS_W + TAG_W;
  localparam int unsigned CW   = $clog2(DEPTH + 1);

  logic [TS_W-1:0]  now;
  logic [EW-1:0]    head;
  logic [TS_W-1:0]  head_rel, age;
  logic [TAG_W-1:0] head_tag;
  logic [CW-1:0]    occ;
  logic             full, empty, due, push_acc;
  wr_src_e          src;
  logic             wr_valid_q;
  logic [TAG_W-1:0] wr_tag_q;

  tdq_stamp_ctr #(.TS_W(TS_W)) i_stamp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .now_o (now)
  );

  // full is judged on occupancy before this edge's release
  assign push_acc = push_valid_i && !bypass_i && !full;

  tdq_ring #(.W(EW), .DEPTH(DEPTH)) i_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push_acc),
    .data_i ({now + TS_W'(DELAY), push_tag_i}),
    .pop_i  (due),
    .head_o (head),
    .count_o(occ),
    .full_o (full),
    .empty_o(empty)
  );

  assign head_rel = head[EW-1:TAG_W];
  assign head_tag = head[TAG_W-1:0];
  // wrap-safe: release once now - rel is non-negative in modular sense
  assign age = now - head_rel;
  assign due = !empty && !age[TS_W-1];

  always_comb begin
    if (due)                           src = WR_RELEASE;
    else if (bypass_i && push_valid_i) src = WR_BYPASS;
    else                               src = WR_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_q <= 1'b0;
      wr_tag_q   <= '0;
    end else begin
      wr_valid_q <= (src != WR_NONE);
      case (src)
        WR_RELEASE: wr_tag_q <= head_tag;
        WR_BYPASS:  wr_tag_q <= push_tag_i;
        default:    wr_tag_q <= wr_tag_q;
      endcase
    end
  end

  assign wr_valid_o = wr_valid_q;
  assign wr_tag_o   = wr_tag_q;
endmodule

// File: rtl/tag_delay_queue_chk.sv
module tag_delay_queue_chk #(
  parameter int unsigned TAG_W = 16,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bypass_i,
  input logic             push_valid_i,
  input logic [TAG_W-1:0] push_tag_i,
  input logic             wr_valid_o,
  input logic [TAG_W-1:0] wr_tag_o,
  input logic             due_i,
  input logic             push_acc_i,
  input logic [CW-1:0]    count_i
);
  AST_BYPASS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i && push_valid_i && !due_i |=> wr_valid_o && wr_tag_o == $past(push_tag_i)); // R5
  AST_RELEASE_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_i |=> wr_valid_o); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !due_i && !(bypass_i && push_valid_i) |=> !wr_valid_o); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH)); // R3
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i == CW'(DEPTH) && !due_i |=> count_i == CW'(DEPTH)); // R3
  AST_PUSH_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_acc_i && due_i |=> $stable(count_i)); // R8
  AST_BYPASS_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i && due_i |=> count_i == $past(count_i) - 1'b1); // R9
  AST_EMPTY_NOT_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i == '0 |-> !due_i); // R4
endmodule

bind tag_delay_queue tag_delay_queue_chk #(
  .TAG_W(TAG_W), .DEPTH(DEPTH), .CW(CW)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bypass_i    (bypass_i),
  .push_valid_i(push_valid_i),
  .push_tag_i  (push_tag_i),
  .wr_valid_o  (wr_valid_o),
  .wr_tag_o    (wr_tag_o),
  .due_i       (due),
  .push_acc_i  (push_acc),
  .count_i     (occ)
);

// File: tb/test_tag_delay_queue.sv
module test_tag_delay_queue;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 8;
  localparam int DEPTH = 4;
  localparam int DELAY = 6;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             bypass_i = 1'b0;
  logic             push_valid_i = 1'b0;
  logic [TAG_W-1:0] push_tag_i = '0;
  logic             wr_valid_o;
  logic [TAG_W-1:0] wr_tag_o;

  int total = 0;
  int bad = 0;
  int n = 0;
  int mrel[$];
  logic [TAG_W-1:0] mtag[$];
  string phase = "R2";
  logic [15:0] lf = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_delay_queue #(.TAG_W(TAG_W), .DEPTH(DEPTH), .DELAY(DELAY)) i_tag_delay_queue (
    .clk_i(clk), .rst_ni(rst_ni), .bypass_i(bypass_i), .push_valid_i(push_valid_i),
    .push_tag_i(push_tag_i), .wr_valid_o(wr_valid_o), .wr_tag_o(wr_tag_o)
  );

  task automatic check(input string req, input logic ev, input logic [TAG_W-1:0] et);
    total++;
    if (wr_valid_o !== ev || (ev && wr_tag_o !== et)) begin
      bad++;
      $display("FAIL %s: got valid=%0b tag=%02h, expected valid=%0b tag=%02h (cycle %0d)",
               req, wr_valid_o, wr_tag_o, ev, et, n);
    end
  endtask

  // called at a negedge: drive, predict, advance one edge, compare
  task automatic step(input logic byp, input logic pv, input logic [TAG_W-1:0] tg);
    logic ev;
    logic [TAG_W-1:0] et;
    logic due;
    int occ;
    bypass_i = byp; push_valid_i = pv; push_tag_i = tg;
    occ = mrel.size();
    due = (occ > 0) && (n >= mrel[0]);
    ev = 1'b0; et = '0;
    if (due) begin
      ev = 1'b1; et = mtag[0];
      void'(mrel.pop_front()); void'(mtag.pop_front());
    end else if (byp && pv) begin
      ev = 1'b1; et = tg;
    end
    if (!byp && pv && occ < DEPTH) begin
      mrel.push_back(n + DELAY); mtag.push_back(tg);
    end
    n++;
    @(posedge clk); @(negedge clk);
    check(phase, ev, et);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1'b0, 1'b0, '0);
  endtask

  task automatic lf_next();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got running, expected finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", 1'b0, '0);
    rst_ni = 1'b1;
    idle(3);
    phase = "R1"; check("R1", 1'b0, '0);

    // R2: single push latency
    phase = "R2"; step(1'b0, 1'b1, 8'h11); idle(DELAY + 3);

    // R3: overflow with back-to-back pushes
    phase = "R3";
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 8'h30 + 8'(i));
    idle(DELAY + DEPTH + 2);

    // R8: push every cycle and every other cycle while releases run
    phase = "R8";
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 8'h40 + 8'(i));
    for (int i = 0; i < 30; i++) step(1'b0, 1'(i % 2 == 0), 8'h80 + 8'(i));
    idle(DELAY + 2);

    // R5: plain bypass
    phase = "R5";
    for (int i = 0; i < 10; i++) step(1'b1, 1'(i % 3 != 1), 8'hA0 + 8'(i));

    // R6 / R9: queued entries drain under bypass, colliding pushes lost
    phase = "R9";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 8'hC0 + 8'(i));
    phase = "R6";
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 8'hD0 + 8'(i));
    idle(4);

    // R7: long idle gaps beyond counter period
    phase = "R7";
    for (int r = 0; r < 4; r++) begin
      idle(37 + r * 11);
      step(1'b0, 1'b1, 8'hE0 + 8'(r));
      step(1'b0, 1'b1, 8'hF0 + 8'(r));
      idle(DELAY + 2);
    end

    // R4: pseudo-random sweep with varying density and mode
    phase = "R4";
    for (int i = 0; i < 4000; i++) begin
      logic byp, pv;
      lf_next();
      byp = (i % 500) > 420 ? lf[3] : 1'b0;
      case ((i / 250) % 4)
        0: pv = lf[0];
        1: pv = lf[0] & lf[1];
        2: pv = lf[0] | lf[1];
        default: pv = 1'b1;
      endcase
      step(byp, pv, lf[15:8]);
    end
    idle(DELAY + 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule